// File: doc/BRIEF.md
# Fail-Safe Primary Clock Monitor

This block supervises the primary system clock of a small controller. It runs on the internal oscillator clock (`clk`). The primary clock enters as an asynchronous input. It is synchronised and reduced to a rising-edge pulse. A sample window of `WIN_CYCLES` internal-oscillator cycles then checks whether the primary clock is still toggling. If a whole window passes with no primary edge, the block enters the fail-safe state:
- the effective clock-select output is forced to the internal-oscillator code;
- a sticky interrupt flag is raised;
- a one-cycle watchdog-clear pulse is issued, if the watchdog is enabled.

The primary oscillator type is given by a mode code. For external-clock, RC and internal modes, monitoring is active as soon as reset or wake-up ends. For crystal or resonator modes, a start-up timer first counts `OST_LEN` primary edges. During that count the internal oscillator stands in as system clock, and monitoring is held off so that a slow-starting crystal is not reported as failed.

Software leaves the fail-safe state by clearing the flag and then writing a new clock-select value. Entering sleep also leaves the fail-safe state. Waking restarts the start-up timer, so a crystal that failed earlier is tried again.

Top module: `fail_safe_clock_monitor`

## Requirements
- R1: Reset state: during and after synchronous active-low reset, `clk_sel_o` is 2'b00 in non-crystal modes and 2'b10 in crystal modes. `ost_done_o`, `fail_flag_o` and `wdt_clr_o` are 0.
- R2: A failure is detected at the last cycle of a sample window of `WIN_CYCLES` cycles in which no synchronised primary rising edge was seen. Its effects appear at the ports on the next clock.
- R3: While the fail-safe state is active, `clk_sel_o` reads 2'b10, the internal-oscillator code.
- R4: A failure produces exactly one cycle of `wdt_clr_o` = 1 when `wdt_en_i` was 1. It produces none when `wdt_en_i` was 0.
- R5: `fail_flag_o` is set by a failure and stays set until a `flag_clr_i` pulse, even across sleep and wake.
- R6: Modes with bit 2 clear (0 external, 1 RC, 2 internal) are monitored immediately after reset or wake.
- R7: Modes with bit 2 set (4, 5, 6: crystal or resonator types) hold `clk_sel_o` at 2'b10 while awake and `ost_done_o` is 0. No failure is detected in that time.
- R8: `ost_done_o` rises after `OST_LEN` primary rising edges counted while awake. Reset and `wake_i` return it to 0.
- R9: A `sw_sel_wr_i` pulse releases the fail-safe state only if `fail_flag_o` is 0 or `flag_clr_i` is high in the same cycle. A write while the flag stays set leaves `clk_sel_o` at 2'b10.
- R10: `sleep_i` ends the fail-safe state and stops monitoring until `wake_i`.
- R11: Outside forced selection, `clk_sel_o` equals the last value written through `sw_sel_i` with `sw_sel_wr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock, also the sample domain |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_clk_i | input | 1 | Primary clock, asynchronous to `clk` |
| osc_mode_i | input | 3 | Primary oscillator type; bit 2 set means crystal or resonator |
| wdt_en_i | input | 1 | Watchdog enabled |
| sleep_i | input | 1 | Pulse: device enters sleep |
| wake_i | input | 1 | Pulse: device wakes from sleep |
| sw_sel_i | input | 2 | Software clock-select value |
| sw_sel_wr_i | input | 1 | Write strobe for `sw_sel_i` |
| flag_clr_i | input | 1 | Software clear of the failure flag |
| clk_sel_o | output | 2 | Effective clock-select value |
| ost_done_o | output | 1 | Start-up timer expired |
| fail_flag_o | output | 1 | Sticky clock-failure interrupt flag |
| wdt_clr_o | output | 1 | One-cycle watchdog clear pulse |

## Verification
A window counter or edge-seen bit that is out of step shows up as a failure flag that rises one window too early, or that never rises after the primary clock stops. The cycle-exact model exposes this at the first window boundary, within `WIN_CYCLES` cycles. A wrong start-up count or a missed wake restart changes the cycle in which `ost_done_o` rises, and the cycle in which a crystal-mode `clk_sel_o` leaves 2'b10. A fail-safe state that is stuck or released early is visible on `clk_sel_o` in the cycle after the write strobe.

// File: rtl/fscm_pkg.sv
// Package: shared codes and helpers for the fail-safe clock monitor.
// Assumes a 3-bit oscillator mode code whose bit 2 marks crystal/resonator types.
package fscm_pkg;

    typedef enum logic [2:0] {
        OSC_EXT = 3'd0,
        OSC_RC  = 3'd1,
        OSC_INT = 3'd2,
        OSC_LP  = 3'd4,
        OSC_XT  = 3'd5,
        OSC_HS  = 3'd6
    } osc_mode_e;

    localparam logic [1:0] SEL_INTOSC = 2'b10;
    localparam logic [1:0] SEL_RESET  = 2'b00;

    // True when the mode needs a start-up timer before monitoring.
    function automatic logic needs_startup(input logic [2:0] mode);
        return mode[2];
    endfunction

endpackage

// File: rtl/fscm_edge_sync.sv
// Module: fscm_edge_sync
// Brings an asynchronous primary clock into the sample domain through a
// flop chain of SYNC_STAGES stages and emits a one-cycle pulse per rising edge.
// Assumes the primary clock period is over two sample-domain cycles.
module fscm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // First stage captures the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    // Remaining stages settle metastability.
    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/fscm_start_timer.sv
// Module: fscm_start_timer
// Counts primary rising edges after reset or wake-up and raises done_o
// once OST_LEN edges are counted. restart_i zeroes it; run_i gates counting.
module fscm_start_timer #(
    parameter int OST_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic edge_i,
    output logic done_o
);

    localparam int CW = (OST_LEN > 1) ? $clog2(OST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Edge counter with terminal flag; restart wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (run_i && !done_q && edge_i) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/fscm_activity_window.sv
// Module: fscm_activity_window
// Splits time into windows of WIN_CYCLES cycles while armed_i is high and
// reports miss_o on the last cycle of a window that saw no edge.
// A disarmed cycle restarts the window from zero.
module fscm_activity_window #(
    parameter int WIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic block_i,
    input  logic edge_i,
    output logic miss_o
);

    localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    logic [WW-1:0] cnt_q;
    logic          seen_q;
    logic          at_end;

    assign at_end = (cnt_q == LAST);

    // Window position and edge-seen memory.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (at_end) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            seen_q <= seen_q | edge_i;
        end
    end

    assign miss_o = armed_i & at_end & ~seen_q & ~edge_i & ~block_i;

endmodule

// File: rtl/fail_safe_clock_monitor.sv
// Module: fail_safe_clock_monitor
// Top of the fail-safe clock monitor. Combines the edge synchroniser, the
// start-up timer and the activity window, and holds the fail-safe state,
// the sticky flag, the watchdog clear pulse and the software select.
// Assumes clk is the always-running internal oscillator.
module fail_safe_clock_monitor
    import fscm_pkg::*;
#(
    parameter int WIN_CYCLES  = 16,
    parameter int OST_LEN     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_clk_i,
    input  logic [2:0] osc_mode_i,
    input  logic       wdt_en_i,
    input  logic       sleep_i,
    input  logic       wake_i,
    input  logic [1:0] sw_sel_i,
    input  logic       sw_sel_wr_i,
    input  logic       flag_clr_i,
    output logic [1:0] clk_sel_o,
    output logic       ost_done_o,
    output logic       fail_flag_o,
    output logic       wdt_clr_o
);

    logic       pri_rise;
    logic       ost_done;
    logic       miss;
    logic       armed;
    logic       xtal;
    logic       asleep_q;
    logic       fs_q;
    logic       flag_q;
    logic       wdt_q;
    logic [1:0] sel_q;
    logic       release_ok;

    assign xtal       = needs_startup(osc_mode_i);
    assign armed      = ~asleep_q & ~fs_q & (~xtal | ost_done);
    assign release_ok = sw_sel_wr_i & (~flag_q | flag_clr_i);

    fscm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pri_clk_i),
        .rise_o  (pri_rise)
    );

    fscm_start_timer #(.OST_LEN(OST_LEN)) u_ost (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (wake_i),
        .run_i     (~asleep_q),
        .edge_i    (pri_rise),
        .done_o    (ost_done)
    );

    fscm_activity_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (armed),
        .block_i (sleep_i),
        .edge_i  (pri_rise),
        .miss_o  (miss)
    );

    // Sleep state tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)       asleep_q <= 1'b0;
        else if (sleep_i) asleep_q <= 1'b1;
        else if (wake_i)  asleep_q <= 1'b0;
    end

    // Fail-safe state: set on a miss, left on sleep or an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n)          fs_q <= 1'b0;
        else if (sleep_i)    fs_q <= 1'b0;
        else if (miss)       fs_q <= 1'b1;
        else if (release_ok) fs_q <= 1'b0;
    end

    // Sticky interrupt flag; a new failure wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (miss)       flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // One-cycle watchdog clear on failure when the watchdog runs.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_q <= 1'b0;
        else        wdt_q <= miss & wdt_en_i;
    end

    // Software clock-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)           sel_q <= SEL_RESET;
        else if (sw_sel_wr_i) sel_q <= sw_sel_i;
    end

    // Effective select: forced to the internal oscillator on failure or crystal start-up.
    always_comb begin
        if (fs_q || (xtal && !ost_done && !asleep_q)) clk_sel_o = SEL_INTOSC;
        else                                          clk_sel_o = sel_q;
    end

    assign ost_done_o  = ost_done;
    assign fail_flag_o = flag_q;
    assign wdt_clr_o   = wdt_q;

endmodule

// File: rtl/fscm_checker.sv
// Module: fscm_checker
// Temporal properties of the fail-safe clock monitor, bound to the top.
module fscm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] osc_mode_i,
    input logic       wdt_en_i,
    input logic       wake_i,
    input logic       flag_clr_i,
    input logic [1:0] clk_sel_o,
    input logic       ost_done_o,
    input logic       fail_flag_o,
    input logic       wdt_clr_o,
    input logic       asleep
);

    AST_FAIL_FORCES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag_o) |-> clk_sel_o == 2'b10);                        // R3

    AST_WDT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |-> $past(wdt_en_i));                                    // R4

    AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o);                                         // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_flag_o) |-> $past(flag_clr_i));                         // R5

    AST_XTAL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_mode_i[2] && !ost_done_o && !asleep) |-> clk_sel_o == 2'b10); // R7

    AST_NO_FAIL_IN_OST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag_o) |-> !($past(osc_mode_i[2]) && !$past(ost_done_o))); // R7

    AST_WAKE_RESTARTS_OST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_i) |-> !ost_done_o);                                    // R8

endmodule

bind fail_safe_clock_monitor fscm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_mode_i  (osc_mode_i),
    .wdt_en_i    (wdt_en_i),
    .wake_i      (wake_i),
    .flag_clr_i  (flag_clr_i),
    .clk_sel_o   (clk_sel_o),
    .ost_done_o  (ost_done_o),
    .fail_flag_o (fail_flag_o),
    .wdt_clr_o   (wdt_clr_o),
    .asleep      (asleep_q)
);

// File: tb/sim_fail_safe_clock_monitor.sv
module sim_fail_safe_clock_monitor;

    localparam int CLK_P    = 10;
    localparam int WIN      = 16;
    localparam int OSTN     = 1024;
    localparam int PRI_HALF = 2;
    localparam int MAX_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri_clk = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       wdt_en = 1'b1;
    logic       sleep_p = 1'b0;
    logic       wake_p = 1'b0;
    logic [1:0] sw_sel = 2'b00;
    logic       sw_wr = 1'b0;
    logic       fclr = 1'b0;
    logic [1:0] clk_sel;
    logic       ost_done;
    logic       fail_flag;
    logic       wdt_clr;

    int n_chk = 0;
    int n_fail = 0;
    int wdt_seen = 0;
    bit pri_run = 1'b0;
    bit finished = 1'b0;

    fail_safe_clock_monitor #(.WIN_CYCLES(WIN), .OST_LEN(OSTN), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pri_clk_i(pri_clk), .osc_mode_i(mode),
        .wdt_en_i(wdt_en), .sleep_i(sleep_p), .wake_i(wake_p), .sw_sel_i(sw_sel),
        .sw_sel_wr_i(sw_wr), .flag_clr_i(fclr), .clk_sel_o(clk_sel),
        .ost_done_o(ost_done), .fail_flag_o(fail_flag), .wdt_clr_o(wdt_clr)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Primary clock generator, stoppable.
    int ph = 0;
    always @(negedge clk) if (pri_run) begin
        ph++;
        if (ph >= PRI_HALF) begin ph = 0; pri_clk <= ~pri_clk; end
    end

    // Reference model: primary history queue plus behavioural state.
    bit q[$] = '{0, 0, 0};
    bit m_asleep, m_fs, m_flag, m_wdt, m_done;
    int m_sel, m_ost, m_win;
    bit m_seen;

    always @(posedge clk) begin
        bit rise, xtal, armed, miss, rn;
        rn = rst_n;
        if (!rn) begin
            m_asleep = 0; m_fs = 0; m_flag = 0; m_wdt = 0; m_done = 0;
            m_sel = 0; m_ost = 0; m_win = 0; m_seen = 0;
            q = '{0, 0, 0};
        end else begin
            rise  = q[1] && !q[2];
            xtal  = mode[2];
            armed = !m_asleep && !m_fs && (!xtal || m_done);
            miss  = 0;
            if (!armed) begin m_win = 0; m_seen = 0; end
            else if (m_win == WIN - 1) begin
                miss = !m_seen && !rise && !sleep_p;
                m_win = 0; m_seen = 0;
            end else begin m_win++; m_seen = m_seen || rise; end
            if (wake_p) begin m_ost = 0; m_done = 0; end
            else if (!m_asleep && !m_done && rise) begin
                if (m_ost == OSTN - 1) m_done = 1; else m_ost++;
            end
            if (sleep_p) m_fs = 0;
            else if (miss) m_fs = 1;
            else if (sw_wr && (!m_flag || fclr)) m_fs = 0;
            if (miss) m_flag = 1; else if (fclr) m_flag = 0;
            m_wdt = miss && wdt_en;
            if (sw_wr) m_sel = sw_sel;
            if (sleep_p) m_asleep = 1; else if (wake_p) m_asleep = 0;
            q.push_front(pri_clk);
            q = q[0:2];
        end
        #1;
        if (rn && !finished) begin
            int exp_sel;
            exp_sel = (m_fs || (mode[2] && !m_done && !m_asleep)) ? 2 : m_sel;
            check(clk_sel == exp_sel[1:0], "R3/R11 clk_sel", clk_sel, exp_sel);
            check(fail_flag == m_flag, "R2/R5 fail_flag", fail_flag, m_flag);
            check(ost_done == m_done, "R8 ost_done", ost_done, m_done);
            check(wdt_clr == m_wdt, "R4 wdt_clr", wdt_clr, m_wdt);
            if (wdt_clr) wdt_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode = m;
        cyc(3);
        check(clk_sel == (m[2] ? 2'd2 : 2'd0) && !ost_done && !fail_flag && !wdt_clr,
              "R1 reset state", clk_sel, m[2] ? 2 : 0);
        rst_n = 1'b1;
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int w0;
        do_reset(3'd0);
        pri_run = 1;
        cyc(200);
        check(fail_flag == 0, "R6 no failure while primary runs", fail_flag, 0);
        pri_run = 0; w0 = wdt_seen;
        cyc(45);
        check(fail_flag == 1, "R2 failure after silent window", fail_flag, 1);
        check(clk_sel == 2'd2, "R3 forced internal select", clk_sel, 2);
        check(wdt_seen - w0 == 1, "R4 one watchdog pulse", wdt_seen - w0, 1);
        sw_sel = 2'b01; pulse(sw_wr); cyc(2);
        check(clk_sel == 2'd2, "R9 write with flag set keeps forced select", clk_sel, 2);
        pri_run = 1; cyc(20);
        check(fail_flag == 1, "R5 flag sticky", fail_flag, 1);
        pulse(fclr); cyc(1);
        check(fail_flag == 0, "R5 flag cleared", fail_flag, 0);
        check(clk_sel == 2'd2, "R9 clear alone keeps forced select", clk_sel, 2);
        sw_sel = 2'b11; pulse(sw_wr); cyc(1);
        check(clk_sel == 2'd3, "R9 R11 release to written select", clk_sel, 3);
        cyc(100);
        check(fail_flag == 0, "R6 monitoring resumes cleanly", fail_flag, 0);

        do_reset(3'd5);
        pri_run = 0; cyc(300);
        check(fail_flag == 0 && clk_sel == 2'd2 && !ost_done, "R7 no detection during start-up",
              fail_flag, 0);
        pri_run = 1; cyc(OSTN * 2 * PRI_HALF + 100);
        check(ost_done == 1, "R8 start-up timer expired", ost_done, 1);
        check(clk_sel == 2'd0, "R11 select returns to software value", clk_sel, 0);
        wdt_en = 1'b0; pri_run = 0; w0 = wdt_seen;
        cyc(45);
        check(fail_flag == 1 && clk_sel == 2'd2, "R2 crystal failure", fail_flag, 1);
        check(wdt_seen == w0, "R4 no pulse with watchdog off", wdt_seen - w0, 0);
        pulse(sleep_p); cyc(100);
        check(clk_sel == 2'd0, "R10 sleep leaves fail-safe", clk_sel, 0);
        pulse(wake_p); cyc(1);
        check(ost_done == 0, "R8 wake restarts timer", ost_done, 0);
        check(clk_sel == 2'd2, "R10 wake retries crystal", clk_sel, 2);
        check(fail_flag == 1, "R5 flag survives sleep", fail_flag, 1);
        pulse(fclr); cyc(300);
        check(fail_flag == 0, "R7 silent crystal not flagged after wake", fail_flag, 0);
        summary();
    end

endmodule